// File: doc/BRIEF.md
# Receive Packet Output Flagging Unit

This block sits behind a Reed-Solomon decoder and presents decoded packets on a byte-wide receive port. The decoder hands over one byte per valid cycle, in packet order: first the sync byte, then the payload bytes, then the sixteen parity bytes. The parity bytes are always part of the stream, even when encoding was turned off at the far end. The block counts each byte's position inside the packet and attaches three flags to it. A sync marker shows the first byte. A data-valid flag is raised only for payload bytes. A packet-good flag carries the decoder's verdict that the packet is correctable.

A mode input selects the packet size. In external-sync mode a packet is 240 bytes long with 223 payload bytes. In internal-sync mode it is 255 bytes long with 238 payload bytes. The block samples the mode only when a packet starts.

The output is timed by a gated copy of the process clock. This clock shows one high phase for every byte put out and stays low otherwise. Byte and flags change only on the falling clock edge, so a receiver can capture them on the rising edge of the gated clock.

Top module: `rx_pkt_flagger`

## Requirements
- R1: Each packet is emitted as one sync byte, then the payload bytes, then exactly 16 parity bytes; its total length is 240 bytes when ext_sync_i=1 and 255 bytes when ext_sync_i=0. The first byte accepted after reset is the sync byte of a new packet.
- R2: out_sync_o is 1 only while the first byte of a packet (position 0) is on out_byte_o.
- R3: out_dv_o is 1 only for payload positions (1 to 223 in external mode, 1 to 238 in internal mode) and is 0 for the sync byte and all parity bytes.
- R4: out_ok_o takes the value of dec_ok_i sampled with the sync byte and holds it, regardless of later dec_ok_i changes, for every byte of that packet.
- R5: ext_sync_i is sampled only with a packet's sync byte; a change during a packet alters the length of the next packet only.
- R6: out_clk_o has exactly one high phase per accepted byte, in the clock cycle after the byte is accepted, and is low in every other phase.
- R7: out_byte_o and the flags change only at falling edges of clk_i following an accepted byte, are stable during each out_clk_o high phase, and hold while no byte is put out.
- R8: Bytes leave in the order they arrive, unchanged: a byte sampled on a rising edge of clk_i is on out_byte_o from the next falling edge on.
- R9: While rst_ni is low, all outputs are 0 with out_clk_o low, and the packet position returns to the sync byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Process clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_sync_i | input | 1 | Packet size select: 1 = 240 bytes, 0 = 255 bytes |
| dec_vld_i | input | 1 | A decoded byte is present this cycle |
| dec_byte_i | input | 8 | Decoded byte |
| dec_ok_i | input | 1 | Decoder reports the packet correctable (used with the sync byte) |
| out_clk_o | output | 1 | Gated process clock, one pulse per output byte |
| out_byte_o | output | 8 | Output byte |
| out_sync_o | output | 1 | Sync byte marker |
| out_dv_o | output | 1 | Payload byte flag |
| out_ok_o | output | 1 | Packet correctable flag |

## Verification
The bench first sends back-to-back internal-mode packets, which fixes the position count and the parity tail without gaps. It then sends external-mode packets with regular idle gaps, which shows whether the position counter and the output registers hold across cycles without a byte. A long random phase toggles the mode, the status bit and the valid input every cycle, so it separates correct once-per-packet sampling of mode and status from sampling on every byte. A reset in the middle of a packet checks that the next accepted byte is treated as a sync byte. Each cycle, the bench samples the outputs twice during the high phase and once during the low phase, so a pulse placed in the wrong phase or data moving during a pulse shows up.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  typedef enum logic {
    MODE_INT = 1'b0,  // long packet
    MODE_EXT = 1'b1   // short packet
  } pkt_mode_e;

  typedef struct packed {
    logic sync;
    logic dv;
    logic ok;
  } out_flags_t;

endpackage

// File: rtl/rxpf_pos_ctr.sv
module rxpf_pos_ctr
  import rxpf_pkg::*;
#(
  parameter int unsigned LEN_EXT = 240,
  parameter int unsigned LEN_INT = 255,
  parameter int unsigned PAR_LEN = 16,
  parameter int unsigned POS_W   = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      vld_i,
  input  pkt_mode_e mode_i,
  output logic      first_o,
  output logic      payload_o
);

  localparam logic [POS_W-1:0] LAST_EXT = POS_W'(LEN_EXT - 1);
  localparam logic [POS_W-1:0] LAST_INT = POS_W'(LEN_INT - 1);
  localparam logic [POS_W-1:0] PAR_W    = POS_W'(PAR_LEN);

  logic [POS_W-1:0] pos_q, last_q, last_mode, last_cur;

  assign last_mode = (mode_i == MODE_EXT) ? LAST_EXT : LAST_INT;
  assign first_o   = (pos_q == '0);
  // mode only counts at packet start
  assign last_cur  = first_o ? last_mode : last_q;
  assign payload_o = !first_o && (pos_q <= (last_cur - PAR_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      last_q <= LAST_INT;
    end else if (vld_i) begin
      last_q <= last_cur;
      pos_q  <= (pos_q == last_cur) ? '0 : pos_q + POS_W'(1);
    end
  end

endmodule

// File: rtl/rxpf_flag_stage.sv
module rxpf_flag_stage
  import rxpf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ok_i,
  input  logic              first_i,
  input  logic              payload_i,
  output logic              stg_vld_o,
  output logic [BYTE_W-1:0] stg_data_o,
  output out_flags_t        stg_flags_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_vld_o   <= 1'b0;
      stg_data_o  <= '0;
      stg_flags_o <= '0;
    end else begin
      stg_vld_o <= vld_i;
      if (vld_i) begin
        stg_data_o       <= data_i;
        stg_flags_o.sync <= first_i;
        stg_flags_o.dv   <= payload_i;
        // status latched once per packet
        if (first_i) stg_flags_o.ok <= ok_i;
      end
    end
  end

endmodule

// File: rtl/rxpf_out_drv.sv
module rxpf_out_drv
  import rxpf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stg_vld_i,
  input  logic [BYTE_W-1:0] stg_data_i,
  input  out_flags_t        stg_flags_i,
  output logic              gate_o,
  output logic              out_clk_o,
  output logic [BYTE_W-1:0] out_data_o,
  output out_flags_t        out_flags_o
);

  // launch on the falling edge: gate settles while clk is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o      <= 1'b0;
      out_data_o  <= '0;
      out_flags_o <= '0;
    end else begin
      gate_o <= stg_vld_i;
      if (stg_vld_i) begin
        out_data_o  <= stg_data_i;
        out_flags_o <= stg_flags_i;
      end
    end
  end

  assign out_clk_o = clk_i & gate_o;

endmodule

// File: rtl/rx_pkt_flagger.sv
module rx_pkt_flagger
  import rxpf_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LEN_EXT = 240,
  parameter int unsigned LEN_INT = 255,
  parameter int unsigned PAR_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_sync_i,
  input  logic              dec_vld_i,
  input  logic [BYTE_W-1:0] dec_byte_i,
  input  logic              dec_ok_i,
  output logic              out_clk_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_sync_o,
  output logic              out_dv_o,
  output logic              out_ok_o
);

  localparam int unsigned LEN_MAX = (LEN_INT > LEN_EXT) ? LEN_INT : LEN_EXT;
  localparam int unsigned POS_W   = $clog2(LEN_MAX);

  logic              is_first, is_payload;
  logic              stg_vld;
  logic [BYTE_W-1:0] stg_data;
  out_flags_t        stg_flags;
  out_flags_t        out_flags;
  logic              out_gate;

  rxpf_pos_ctr #(
    .LEN_EXT(LEN_EXT),
    .LEN_INT(LEN_INT),
    .PAR_LEN(PAR_LEN),
    .POS_W  (POS_W)
  ) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (dec_vld_i),
    .mode_i   (pkt_mode_e'(ext_sync_i)),
    .first_o  (is_first),
    .payload_o(is_payload)
  );

  rxpf_flag_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (dec_vld_i),
    .data_i     (dec_byte_i),
    .ok_i       (dec_ok_i),
    .first_i    (is_first),
    .payload_i  (is_payload),
    .stg_vld_o  (stg_vld),
    .stg_data_o (stg_data),
    .stg_flags_o(stg_flags)
  );

  rxpf_out_drv #(.BYTE_W(BYTE_W)) u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stg_vld_i  (stg_vld),
    .stg_data_i (stg_data),
    .stg_flags_i(stg_flags),
    .gate_o     (out_gate),
    .out_clk_o  (out_clk_o),
    .out_data_o (out_byte_o),
    .out_flags_o(out_flags)
  );

  assign out_sync_o = out_flags.sync;
  assign out_dv_o   = out_flags.dv;
  assign out_ok_o   = out_flags.ok;

endmodule

// File: rtl/rx_pkt_flagger_chk.sv
module rx_pkt_flagger_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stg_vld_i,
  input logic              stg_sync_i,
  input logic              stg_ok_i,
  input logic              gate_i,
  input logic              out_sync_i,
  input logic              out_dv_i,
  input logic [BYTE_W-1:0] out_byte_i
);

  // sync and payload flags never coincide (R2, R3)
  assert_sync_dv_excl_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(out_sync_i && out_dv_i));

  // status only reloads on a sync byte
  assert_ok_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_vld_i && !stg_sync_i) |-> $stable(stg_ok_i));

  // one pulse per staged byte, one cycle later
  assert_gate_follows_byte_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    gate_i == $past(stg_vld_i));

  // output data only moves when a byte was launched
  assert_out_hold_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$past(stg_vld_i) |-> $stable(out_byte_i));

endmodule

bind rx_pkt_flagger rx_pkt_flagger_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stg_vld_i (stg_vld),
  .stg_sync_i(stg_flags.sync),
  .stg_ok_i  (stg_flags.ok),
  .gate_i    (out_gate),
  .out_sync_i(out_sync_o),
  .out_dv_i  (out_dv_o),
  .out_byte_i(out_byte_o)
);

// File: tb/rx_pkt_flagger_tb.sv
module rx_pkt_flagger_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_sync = 1'b0;
  logic       vld = 1'b0;
  logic       ok = 1'b0;
  logic [7:0] bval = 8'h00;
  logic       out_clk, out_sync, out_dv, out_ok;
  logic [7:0] out_byte;

  int n_chk = 0;
  int n_fail = 0;

  // expectation word: {pulse, ok, dv, sync, byte}
  logic [11:0] q[$];
  logic [11:0] held = '0;
  int          m_pos = 0;
  int          m_len = 255;
  bit          m_ok = 1'b0;
  logic [7:0]  bcnt = 8'h00;

  always #5 clk = ~clk;

  rx_pkt_flagger u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ext_sync_i(ext_sync),
    .dec_vld_i (vld),
    .dec_byte_i(bval),
    .dec_ok_i  (ok),
    .out_clk_o (out_clk),
    .out_byte_o(out_byte),
    .out_sync_o(out_sync),
    .out_dv_o  (out_dv),
    .out_ok_o  (out_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model: one accepted input byte
  task automatic drive(input bit v, input bit m, input bit o);
    logic [11:0] e;
    bit s, d;
    vld = v; ext_sync = m; ok = o; bval = bcnt;
    if (v) begin
      if (m_pos == 0) begin
        m_len = m ? 240 : 255;
        m_ok  = o;
      end
      s = (m_pos == 0);
      d = (m_pos >= 1) && (m_pos <= m_len - 17);
      e = {1'b1, m_ok, d, s, bcnt};
      held = e;
      m_pos = (m_pos == m_len - 1) ? 0 : m_pos + 1;
      bcnt = bcnt + 8'd1;
    end else begin
      e = {1'b0, held[10:0]};
    end
    q.push_back(e);
  endtask

  task automatic cyc(input bit v, input bit m, input bit o);
    logic [11:0] e;
    @(posedge clk);
    #2;
    e = q.pop_front();
    chk("R8 byte", out_byte, e[7:0]);
    chk("R1,R2 sync", out_sync, e[8]);
    chk("R1,R3,R5 dv", out_dv, e[9]);
    chk("R4 ok", out_ok, e[10]);
    chk("R6 pulse", out_clk, e[11]);
    #1 drive(v, m, o);
    #1;
    chk("R7 byte stable", out_byte, e[7:0]);
    chk("R7 flags stable", {out_ok, out_dv, out_sync}, e[10:8]);
    chk("R6 pulse width", out_clk, e[11]);
    #3;
    chk("R6 low phase", out_clk, 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    vld = 1'b0;
    #1;
    chk("R9 reset outs", {out_clk, out_byte, out_sync, out_dv, out_ok}, 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset hold", {out_clk, out_byte, out_sync, out_dv, out_ok}, 0);
    #1 rst_ni = 1'b1;
    q.delete();
    q.push_back('0);
    held = '0;
    m_pos = 0;
    m_ok = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    // internal mode, back to back, two packets
    for (int i = 0; i < 510; i++) cyc(1'b1, 1'b0, 1'b1);
    // external mode, idle every third cycle
    for (int i = 0; i < 540; i++) cyc((i % 3) != 2, 1'b1, 1'b0);
    // mode, status and valid change freely
    for (int i = 0; i < 2000; i++)
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    cyc(1'b0, 1'b0, 1'b0);
    // reset in the middle of a packet, then a fresh packet
    do_reset();
    for (int i = 0; i < 245; i++) cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    report();
  end

endmodule